// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash interface and decides whether a program or erase operation inside the flash has finished. The host asserts a start pulse once the command sequence has been written. The poller then issues status reads through a simple request/acknowledge read port. It watches one status bit that the flash flips on every read while it is busy, and a second bit that the flash raises when its internal operation has run out of time.

Every check begins with a pair of reads. The toggle value from the first read is kept and compared against the second. If they agree, the flash has gone quiet and the operation succeeded. If they differ and the timeout flag is clear, the poller starts another pair. If they differ and the timeout flag is set, one confirming pair follows, because the flash may have stopped flipping the bit in the same instant it raised the flag. A quiet confirming pair means success. A still-flipping pair means failure, and a reset-command request is raised. A parameterised limit on the number of pairs stops a device that never settles. An abort input drops all saved state.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, busy_o, rd_req_o, done_ok_o, done_fail_o and reset_req_o are all low after that edge.
- R2: A start_i pulse in idle, with abort_i low, raises busy_o and rd_req_o in the next cycle. A start_i seen while busy has no effect on the sequence of reads or on the result.
- R3: A read is accepted in a cycle where rd_req_o and rd_ack_i are both high. If the toggle bit (rd_data_i bit 6) of the second read of a pair equals that of the first read, done_ok_o pulses one cycle after the second read is accepted, and no further read is requested.
- R4: If the toggle bits of a pair differ and the timeout bit (rd_data_i bit 5) of the second read is 0, a new pair of reads follows. Its first read is stored afresh.
- R5: If the toggle bits of a pair differ and the timeout bit of the second read is 1, exactly two more reads follow. Equal toggle bits on that confirming pair give done_ok_o.
- R6: Differing toggle bits on the confirming pair give done_fail_o and reset_req_o in the same cycle.
- R7: After MAX_PAIRS consecutive pairs that differ with the timeout bit 0, done_fail_o pulses with reset_req_o low, after exactly 2*MAX_PAIRS reads.
- R8: abort_i while busy returns the block to idle in the next cycle with no result pulse, even if a read is acknowledged in that same cycle. The next start needs two fresh reads. abort_i in idle blocks a simultaneous start_i.
- R9: done_ok_o, done_fail_o and reset_req_o are single-cycle pulses. Exactly one of done_ok_o and done_fail_o fires per run. busy_o is low in the pulse cycle and high from the cycle after start until then.
- R10: Bits of rd_data_i other than 6 and 5 do not affect the outcome or the number of reads.
- R11: The pair count behind R7 restarts at every start, so a run that follows a watchdog failure gets the full MAX_PAIRS pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a completion check |
| abort_i | input | 1 | Abandon the check and clear stored state |
| rd_req_o | output | 1 | Status read requested |
| rd_ack_i | input | 1 | Read data valid for the current request |
| rd_data_i | input | DATA_W | Status byte from the flash |
| busy_o | output | 1 | A check is in progress |
| done_ok_o | output | 1 | Pulse: operation completed |
| done_fail_o | output | 1 | Pulse: operation failed or never settled |
| reset_req_o | output | 1 | Pulse: send the reset command to the flash |

## Verification
The hardest case to reach is the confirming pair. The flash must stop flipping the toggle bit at the very read that first shows the timeout flag, or else keep flipping through the confirmation. The bench models the flash as a function of the read index and sweeps the number of busy pairs, the way the operation ends and the acknowledge latency. This lands the timeout read after every possible count of prior pairs, up to and beyond the watchdog limit. Aborts are placed after the first read, inside the confirming pair and against a completing acknowledge.

// File: rtl/tgl_poll_pkg.sv
// Package: shared state encoding for the toggle-bit poller.
// Assumes: nothing beyond being compiled before the modules that use it.
package tgl_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PAIR_A = 3'd1,
        ST_PAIR_B = 3'd2,
        ST_CONF_A = 3'd3,
        ST_CONF_B = 3'd4
    } poll_st_e;

endpackage

// File: rtl/tgl_poll_sample.sv
// Module: holds the toggle bit of the first read of a pair and compares it
// with the toggle bit of the read now on the data bus. It also exposes the
// timeout flag of that read.
// Assumes: data_i is meaningful only while the controller accepts a read.
module tgl_poll_sample #(
    parameter int DATA_W  = 8,
    parameter int TGL_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              same_o,
    output logic              tmo_o
);

    logic held_q;

    // Store the first toggle value of a pair; clear on start or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (clr_i) begin
            held_q <= 1'b0;
        end else if (cap_i) begin
            held_q <= data_i[TGL_BIT];
        end
    end

    // Compare the live toggle bit with the stored one.
    always_comb begin
        same_o = (data_i[TGL_BIT] == held_q);
        tmo_o  = data_i[TMO_BIT];
    end

    AST_HELD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i && !clr_i) |=> $stable(held_q)); // R4

endmodule

// File: rtl/tgl_poll_wdog.sv
// Module: counts the read pairs that are still toggling with no timeout
// flag, and reports when the next such pair would be the last one allowed.
// Assumes: MAX_PAIRS >= 1. inc_i is only raised while last_o is low.
module tgl_poll_wdog #(
    parameter int MAX_PAIRS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CNT_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_PAIRS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Pair counter, restarted at every start and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != LAST_VAL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final allowed pair.
    always_comb begin
        last_o = (cnt_q == LAST_VAL);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL); // R7

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/tgl_poll_fsm.sv
// Module: sequencing for the toggle-bit check. It runs read pairs, branches
// on the compare and timeout results, runs the confirming pair and issues
// the registered result pulses.
// Assumes: same_i and tmo_i are valid in any cycle where a read is accepted.
module tgl_poll_fsm
    import tgl_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic rd_ack_i,
    input  logic same_i,
    input  logic tmo_i,
    input  logic wd_last_i,
    output logic rd_req_o,
    output logic busy_o,
    output logic samp_clr_o,
    output logic samp_cap_o,
    output logic wd_clr_o,
    output logic wd_inc_o,
    output logic done_ok_o,
    output logic done_fail_o,
    output logic reset_req_o
);

    poll_st_e st_q, st_d;
    logic     ok_d, fail_d, rreq_d;
    logic     take;

    // Every non-idle state waits on one read.
    always_comb begin
        rd_req_o = (st_q != ST_IDLE);
        busy_o   = (st_q != ST_IDLE);
        take     = rd_req_o && rd_ack_i;
    end

    // Next-state and result decisions.
    always_comb begin
        st_d       = st_q;
        ok_d       = 1'b0;
        fail_d     = 1'b0;
        rreq_d     = 1'b0;
        samp_clr_o = 1'b0;
        samp_cap_o = 1'b0;
        wd_clr_o   = 1'b0;
        wd_inc_o   = 1'b0;
        if (st_q != ST_IDLE && abort_i) begin
            st_d       = ST_IDLE;
            samp_clr_o = 1'b1;
            wd_clr_o   = 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i && !abort_i) begin
                        st_d       = ST_PAIR_A;
                        samp_clr_o = 1'b1;
                        wd_clr_o   = 1'b1;
                    end
                end
                ST_PAIR_A: begin
                    if (take) begin
                        samp_cap_o = 1'b1;
                        st_d       = ST_PAIR_B;
                    end
                end
                ST_PAIR_B: begin
                    if (take) begin
                        if (same_i) begin
                            ok_d = 1'b1;
                            st_d = ST_IDLE;
                        end else if (tmo_i) begin
                            st_d = ST_CONF_A;
                        end else if (wd_last_i) begin
                            fail_d = 1'b1;
                            st_d   = ST_IDLE;
                        end else begin
                            wd_inc_o = 1'b1;
                            st_d     = ST_PAIR_A;
                        end
                    end
                end
                ST_CONF_A: begin
                    if (take) begin
                        samp_cap_o = 1'b1;
                        st_d       = ST_CONF_B;
                    end
                end
                ST_CONF_B: begin
                    if (take) begin
                        st_d = ST_IDLE;
                        if (same_i) begin
                            ok_d = 1'b1;
                        end else begin
                            fail_d = 1'b1;
                            rreq_d = 1'b1;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            done_ok_o   <= 1'b0;
            done_fail_o <= 1'b0;
            reset_req_o <= 1'b0;
        end else begin
            st_q        <= st_d;
            done_ok_o   <= ok_d;
            done_fail_o <= fail_d;
            reset_req_o <= rreq_d;
        end
    end

    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !abort_i) |=> rd_req_o); // R2

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok_o && done_fail_o)); // R9

    AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_o |=> !done_ok_o); // R9

    AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail_o |=> !done_fail_o); // R9

    AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok_o || done_fail_o) |-> !busy_o); // R9

    AST_RESET_WITH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> done_fail_o); // R6

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> (!busy_o && !done_ok_o && !done_fail_o)); // R8

endmodule

// File: rtl/tgl_poll_ctrl.sv
// Module: top of the toggle-bit completion poller. It wires the sequencer,
// the toggle-value holder and the pair watchdog together.
// Assumes: TGL_BIT and TMO_BIT index into rd_data_i and differ.
module tgl_poll_ctrl #(
    parameter int DATA_W    = 8,
    parameter int TGL_BIT   = 6,
    parameter int TMO_BIT   = 5,
    parameter int MAX_PAIRS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_ok_o,
    output logic              done_fail_o,
    output logic              reset_req_o
);

    logic same, tmo, wd_last;
    logic samp_clr, samp_cap, wd_clr, wd_inc;

    tgl_poll_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .abort_i     (abort_i),
        .rd_ack_i    (rd_ack_i),
        .same_i      (same),
        .tmo_i       (tmo),
        .wd_last_i   (wd_last),
        .rd_req_o    (rd_req_o),
        .busy_o      (busy_o),
        .samp_clr_o  (samp_clr),
        .samp_cap_o  (samp_cap),
        .wd_clr_o    (wd_clr),
        .wd_inc_o    (wd_inc),
        .done_ok_o   (done_ok_o),
        .done_fail_o (done_fail_o),
        .reset_req_o (reset_req_o)
    );

    tgl_poll_sample #(
        .DATA_W  (DATA_W),
        .TGL_BIT (TGL_BIT),
        .TMO_BIT (TMO_BIT)
    ) u_sample (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (samp_clr),
        .cap_i  (samp_cap),
        .data_i (rd_data_i),
        .same_o (same),
        .tmo_o  (tmo)
    );

    tgl_poll_wdog #(
        .MAX_PAIRS (MAX_PAIRS)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (wd_clr),
        .inc_i  (wd_inc),
        .last_o (wd_last)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy_o && !rd_req_o && !done_ok_o && !done_fail_o && !reset_req_o)); // R1

endmodule

// File: tb/tgl_poll_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: sweeps busy-pair counts, end kinds and acknowledge latencies
// against a flash model computed from the read index.
module tgl_poll_ctrl_tb_top;

    localparam int MP = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       abort_i;
    logic       rd_ack_i;
    logic [7:0] rd_data_i;
    logic       rd_req_o, busy_o, done_ok_o, done_fail_o, reset_req_o;

    int nchk  = 0;
    int nfail = 0;
    int ncyc  = 0;

    always #2.5 clk = ~clk;

    tgl_poll_ctrl #(
        .DATA_W    (8),
        .TGL_BIT   (6),
        .TMO_BIT   (5),
        .MAX_PAIRS (MP)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .abort_i     (abort_i),
        .rd_req_o    (rd_req_o),
        .rd_ack_i    (rd_ack_i),
        .rd_data_i   (rd_data_i),
        .busy_o      (busy_o),
        .done_ok_o   (done_ok_o),
        .done_fail_o (done_fail_o),
        .reset_req_o (reset_req_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog on the whole run.
    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: run hung actual=%0d expected=0", ncyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // Flash model: status byte for read r of a scenario (R10 junk bits).
    function automatic logic [7:0] dev_byte(int r, int k, int endk);
        logic [7:0] b;
        logic       t, m;
        b = 8'((r * 37 + 90)) & 8'h9F;
        if (k >= MP || r < 2 * k) begin
            t = r[0];
            m = 1'b0;
        end else begin
            case (endk)
                0: begin t = 1'b0; m = 1'b0; end
                1: begin t = (r != 2 * k); m = (r >= 2 * k + 1); end
                default: begin t = r[0]; m = (r >= 2 * k + 1); end
            endcase
        end
        b[6] = t;
        b[5] = m;
        return b;
    endfunction

    task automatic run_case(input int k, input int endk, input int lat, input bit hold_start);
        int    rd_cnt = 0;
        int    waitc  = 0;
        int    cyc    = 0;
        bit    seen   = 0;
        bit    g_ok = 0, g_fail = 0, g_rst = 0, g_busy = 1, g_req = 1;
        int    exp_reads;
        bit    exp_ok, exp_rst;
        string tag;
        if (k >= MP) begin
            exp_reads = 2 * MP; exp_ok = 0; exp_rst = 0; tag = "R7";
        end else if (endk == 0) begin
            exp_reads = 2 * k + 2; exp_ok = 1; exp_rst = 0; tag = "R3";
        end else if (endk == 1) begin
            exp_reads = 2 * k + 4; exp_ok = 1; exp_rst = 0; tag = "R5";
        end else begin
            exp_reads = 2 * k + 4; exp_ok = 0; exp_rst = 1; tag = "R6";
        end
        start_i = 1'b1;
        @(negedge clk);
        start_i = hold_start;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        chk(rd_req_o == 1'b1, "R2 read request after start", rd_req_o, 1);
        while (!seen && cyc < 400) begin
            if (done_ok_o || done_fail_o) begin
                seen   = 1;
                g_ok   = done_ok_o;
                g_fail = done_fail_o;
                g_rst  = reset_req_o;
                g_busy = busy_o;
                g_req  = rd_req_o;
                rd_ack_i = 1'b0;
                start_i  = 1'b0;
            end else begin
                if (rd_req_o && waitc == lat) begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = dev_byte(rd_cnt, k, endk);
                    rd_cnt++;
                    waitc = 0;
                end else begin
                    rd_ack_i = 1'b0;
                    if (rd_req_o) waitc++;
                end
                cyc++;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(seen, "R9 result pulse seen", seen, 1);
        chk(g_ok == exp_ok, {tag, " done_ok"}, g_ok, exp_ok);
        chk(g_fail == !exp_ok, {tag, " done_fail"}, g_fail, !exp_ok);
        chk(g_rst == exp_rst, {tag, " reset_req"}, g_rst, exp_rst);
        chk(rd_cnt == exp_reads, {tag, " read count R4 R10 R2"}, rd_cnt, exp_reads);
        chk(g_busy == 1'b0, "R9 busy low in pulse cycle", g_busy, 0);
        chk(g_req == 1'b0, "R3 no read after result", g_req, 0);
        @(negedge clk);
        chk(!done_ok_o && !done_fail_o && !reset_req_o, "R9 single-cycle pulse",
            int'(done_ok_o) + int'(done_fail_o) + int'(reset_req_o), 0);
        chk(!rd_req_o, "R3 no further reads", rd_req_o, 0);
    endtask

    // Abort after n accepted reads; the abort cycle also carries an ack.
    task automatic abort_case(input int n);
        logic [7:0] b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int r = 0; r < n; r++) begin
            b = 8'h00;
            b[6] = r[0];
            b[5] = (r == 1);
            rd_ack_i  = 1'b1;
            rd_data_i = b;
            @(negedge clk);
        end
        abort_i   = 1'b1;
        rd_ack_i  = 1'b1;
        rd_data_i = 8'h00;
        @(negedge clk);
        abort_i  = 1'b0;
        rd_ack_i = 1'b0;
        chk(busy_o == 1'b0, "R8 idle after abort", busy_o, 0);
        chk(!done_ok_o && !done_fail_o, "R8 no pulse on abort",
            int'(done_ok_o) + int'(done_fail_o), 0);
        repeat (3) @(negedge clk);
        chk(!done_ok_o && !done_fail_o && !rd_req_o, "R8 quiet after abort",
            int'(done_ok_o) + int'(done_fail_o) + int'(rd_req_o), 0);
        run_case(0, 0, 0, 1'b0);
    endtask

    initial begin
        rst_n     = 1'b0;
        start_i   = 1'b1;
        abort_i   = 1'b0;
        rd_ack_i  = 1'b0;
        rd_data_i = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy_o && !rd_req_o && !done_ok_o && !done_fail_o && !reset_req_o,
            "R1 reset state", int'(busy_o) + int'(rd_req_o), 0);
        start_i = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);

        for (int lat = 0; lat < 3; lat++) begin
            for (int endk = 0; endk < 3; endk++) begin
                for (int k = 0; k <= MP; k++) begin
                    run_case(k, endk, lat, lat == 1);
                end
            end
        end

        // R11: full pair budget right after a watchdog failure.
        run_case(MP, 0, 0, 1'b0);
        run_case(MP - 1, 1, 0, 1'b0);
        run_case(MP, 2, 2, 1'b1);
        run_case(MP - 1, 2, 1, 1'b0);

        abort_case(1);
        abort_case(2);
        abort_case(3);

        // R8: abort in idle blocks a simultaneous start.
        start_i = 1'b1;
        abort_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        abort_i = 1'b0;
        chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R8 abort blocks start in idle",
            int'(busy_o) + int'(rd_req_o), 0);
        run_case(2, 1, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule